// File: doc/BRIEF.md
# Six-Mode Programmable Interval Counter

A single down-counting timer channel whose output waveform is picked at run time from six behaviours: a level that rises at terminal count, a gate-triggered one-shot, a periodic single-clock low pulse, a square wave, a strobe started by the count write, and a strobe started by a gate edge. The counter steps once per rising edge of `clk`. For the level-sensitive modes the `gate` input is an enable. For the triggered modes it is a trigger, and a rising level is detected by comparing it with its value at the previous edge.

A host issues two kinds of single-cycle write. `wr_mode` selects the behaviour and parks the channel. `wr_count` supplies a 16-bit count N. Each write takes effect at the clock edge at which its strobe is sampled high. If both strobes are high in the same cycle, the mode write wins. A gate trigger is acted on only in a cycle with no write.

Top module: `prog_interval_timer`

## Requirements
- R1: After reset the output is low, the selected mode is 0 and no counting takes place.
- R2: At the edge that samples `wr_mode`, counting stops and any loaded count is forgotten. From that edge on, the output is low for mode code 0 and high for codes 1 to 5. Codes 6 and 7 behave as codes 2 and 3.
- R3: Mode 0: at the edge that samples `wr_count`, the output goes low. It rises at the Nth following edge and stays high until the next count write or mode write.
- R4: Mode 0: while `gate` is low at an edge, the count holds its value and the rise of the output is delayed by one clock for each such edge.
- R5: Mode 1: a count write only arms the channel. A gate rising edge seen while armed drives the output low for exactly N clocks, starting at that edge. A gate rising edge before the channel is armed is ignored. Each later rising edge fires again or restarts the pulse.
- R6: Mode 2 (N ≥ 2): the output is high, except that it is low for one clock every N clocks. The first low clock follows the Nth edge after the count write, and the count reloads by itself.
- R7: Mode 3 (N ≥ 2): the output repeats with period N. It is high for ceil(N/2) clocks and then low for floor(N/2) clocks, and the first high half starts at the count-write edge.
- R8: Mode 4: the output stays high, except for exactly one low clock, which follows the Nth edge after the count write. Counting then stops.
- R9: Mode 5: like mode 4, except that counting starts at a gate rising edge after the count write, and the low clock follows the Nth edge after that trigger. A rising edge while counting reloads N.
- R10: A count write while counting in modes 0, 2, 3 or 4 restarts the sequence from the new value at the next edge.
- R11: Mode 3 with an odd N: the high half is exactly one clock longer than the low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_mode | input | 1 | One-cycle strobe that loads `mode_in` |
| mode_in | input | 3 | Mode code 0 to 5 (6 and 7 alias 2 and 3) |
| wr_count | input | 1 | One-cycle strobe that loads `count_in` |
| count_in | input | 16 | Count value N |
| gate | input | 1 | Enable in modes 0, 2, 3 and 4; trigger in modes 1 and 5 |
| out | output | 1 | Timer output waveform |

## Verification
On every cycle, the assertions check the output level after a mode write, that a high mode-0 output persists until a write, that a low gate freezes the mode-0 count, that an unarmed one-shot stays high, and that strobes in modes 2, 4 and 5 last exactly one clock. The distances between events are not local to one cycle, so only the bench scenarios can show them. These are the length N of the mode-1 pulse, the period and odd-count split of the square wave, the position of the strobes, the effect of retriggers and count rewrites, and the ignored trigger before arming.

// File: rtl/pit_pkg.sv
package pit_pkg;
    parameter int CNT_W  = 16;
    parameter int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        PIT_TC_LEVEL = 3'd0,
        PIT_ONESHOT  = 3'd1,
        PIT_RATE     = 3'd2,
        PIT_SQUARE   = 3'd3,
        PIT_SW_STROBE = 3'd4,
        PIT_HW_STROBE = 3'd5
    } pit_mode_e;

    typedef struct packed {
        pit_mode_e        mode;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] reload;
        logic             run;
        logic             loaded;
        logic             out;
    } pit_state_t;

    localparam pit_state_t PIT_RST = '{
        mode: PIT_TC_LEVEL, cnt: '0, reload: '0, run: 1'b0, loaded: 1'b0, out: 1'b0
    };

    // codes 6 and 7 fold onto 2 and 3
    function automatic pit_mode_e pit_decode(input logic [MODE_W-1:0] code);
        logic [MODE_W-1:0] m;
        m = (code[2] && code[1]) ? {1'b0, code[1:0]} : code;
        return pit_mode_e'(m);
    endfunction
endpackage

// File: rtl/pit_edge.sv
module pit_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);
    logic sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    assign rise = sig & ~sig_q;
endmodule

// File: rtl/pit_halves.sv
module pit_halves #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);
    assign lo = val >> 1;
    assign hi = val - lo;
endmodule

// File: rtl/prog_interval_timer.sv
module prog_interval_timer
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_mode,
    input  logic [MODE_W-1:0] mode_in,
    input  logic              wr_count,
    input  logic [CNT_W-1:0]  count_in,
    input  logic              gate,
    output logic              out
);
    pit_state_t       st_d, st_q;
    logic             gate_rise;
    logic [CNT_W-1:0] half_src, half_hi, half_lo;
    logic             trig_mode;
    logic             en_dec;
    logic             term;

    pit_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (gate),
        .rise (gate_rise)
    );

    // one splitter serves both the write path and the reload path
    assign half_src = wr_count ? count_in : st_q.reload;

    pit_halves #(.W(CNT_W)) u_halves (
        .val(half_src),
        .hi (half_hi),
        .lo (half_lo)
    );

    assign trig_mode = (st_q.mode == PIT_ONESHOT) || (st_q.mode == PIT_HW_STROBE);
    assign en_dec    = st_q.run && (trig_mode || gate);
    assign term      = en_dec && (st_q.cnt == CNT_W'(1));

    always_comb begin
        st_d = st_q;
        if (wr_mode) begin
            st_d.mode   = pit_decode(mode_in);
            st_d.run    = 1'b0;
            st_d.loaded = 1'b0;
            st_d.out    = (pit_decode(mode_in) != PIT_TC_LEVEL);
        end else if (wr_count) begin
            st_d.reload = count_in;
            st_d.loaded = 1'b1;
            case (st_q.mode)
                PIT_TC_LEVEL: begin
                    st_d.cnt = count_in;
                    st_d.run = 1'b1;
                    st_d.out = 1'b0;
                end
                PIT_RATE, PIT_SW_STROBE: begin
                    st_d.cnt = count_in;
                    st_d.run = 1'b1;
                    st_d.out = 1'b1;
                end
                PIT_SQUARE: begin
                    st_d.cnt = half_hi;
                    st_d.run = 1'b1;
                    st_d.out = 1'b1;
                end
                default: ;
            endcase
        end else if (gate_rise && st_q.loaded && trig_mode) begin
            st_d.cnt = st_q.reload;
            st_d.run = 1'b1;
            st_d.out = (st_q.mode != PIT_ONESHOT);
        end else begin
            // a strobe lasts one clock
            if (!st_q.out && ((st_q.mode == PIT_RATE) || (st_q.mode == PIT_SW_STROBE)
                              || (st_q.mode == PIT_HW_STROBE)))
                st_d.out = 1'b1;
            if (term) begin
                case (st_q.mode)
                    PIT_RATE: begin
                        st_d.cnt = st_q.reload;
                        st_d.out = 1'b0;
                    end
                    PIT_SQUARE: begin
                        st_d.out = ~st_q.out;
                        st_d.cnt = st_q.out ? half_lo : half_hi;
                    end
                    PIT_SW_STROBE, PIT_HW_STROBE: begin
                        st_d.cnt = '0;
                        st_d.run = 1'b0;
                        st_d.out = 1'b0;
                    end
                    default: begin
                        st_d.cnt = '0;
                        st_d.run = 1'b0;
                        st_d.out = 1'b1;
                    end
                endcase
            end else if (en_dec) begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PIT_RST;
        else        st_q <= st_d;
    end

    assign out = st_q.out;
endmodule

// File: rtl/pit_chk.sv
module pit_chk
    import pit_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_mode,
    input logic [MODE_W-1:0] mode_in,
    input logic              wr_count,
    input logic              gate,
    input logic              out,
    input pit_mode_e         mode_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              loaded_q
);
    // R2: output level after a mode write
    p_mode_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode |=> (out == ($past(mode_in) != '0)));

    // R3: a high mode-0 output holds until a write
    p_level_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PIT_TC_LEVEL && out && !wr_mode && !wr_count) |=> out);

    // R4: a low gate freezes the mode-0 count
    p_gate_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PIT_TC_LEVEL && !gate && !wr_mode && !wr_count) |=> $stable(cnt_q));

    // R5: an unarmed one-shot keeps its output high
    p_unarmed_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PIT_ONESHOT && !loaded_q) |-> out);

    // R6, R8, R9: strobes last one clock
    p_strobe_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == PIT_RATE || mode_q == PIT_SW_STROBE || mode_q == PIT_HW_STROBE)
         && !out && !wr_mode && !wr_count) |=> out);
endmodule

bind prog_interval_timer pit_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_mode (wr_mode),
    .mode_in (mode_in),
    .wr_count(wr_count),
    .gate    (gate),
    .out     (out),
    .mode_q  (st_q.mode),
    .cnt_q   (st_q.cnt),
    .loaded_q(st_q.loaded)
);

// File: tb/prog_interval_timer_bench.sv
module prog_interval_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_mode = 1'b0;
    logic [2:0]  mode_in = '0;
    logic        wr_count = 1'b0;
    logic [15:0] count_in = '0;
    logic        gate = 1'b0;
    logic        out;
    int          checks = 0;
    int          errors = 0;

    // {mode[26:24], count[23:8], trigger delay[7:0]}
    localparam int NROW = 12;
    localparam logic [26:0] VEC [NROW] = '{
        {3'd0, 16'd4, 8'd0}, {3'd0, 16'd1, 8'd0},
        {3'd1, 16'd3, 8'd2}, {3'd1, 16'd1, 8'd1},
        {3'd2, 16'd3, 8'd0}, {3'd2, 16'd2, 8'd0},
        {3'd3, 16'd4, 8'd0}, {3'd3, 16'd5, 8'd0},
        {3'd3, 16'd2, 8'd0}, {3'd4, 16'd3, 8'd0},
        {3'd4, 16'd1, 8'd0}, {3'd5, 16'd4, 8'd3}
    };

    prog_interval_timer u_prog_interval_timer (
        .clk(clk), .rst_n(rst_n), .wr_mode(wr_mode), .mode_in(mode_in),
        .wr_count(wr_count), .count_in(count_in), .gate(gate), .out(out)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // mode write; sample level right after its edge
    task automatic set_mode(input logic [2:0] m, input logic g);
        wr_mode = 1'b1; mode_in = m; gate = g;
        step();
        wr_mode = 1'b0;
        chk("R2 mode write level", int'(out), (m != 3'd0) ? 1 : 0);
    endtask

    // count write; returns at the sample after the load edge (k = 0)
    task automatic load(input int n);
        wr_count = 1'b1; count_in = 16'(n);
        step();
        wr_count = 1'b0;
    endtask

    function automatic int exp_out(input int m, input int n, input int t, input int k);
        case (m)
            0: return (k >= n) ? 1 : 0;
            1: return (k >= t && k < t + n) ? 0 : 1;
            2: return (k >= n && (k % n) == 0) ? 0 : 1;
            3: return ((k % n) < (n - n / 2)) ? 1 : 0;
            4: return (k == n) ? 0 : 1;
            default: return (k == t + n) ? 0 : 1;
        endcase
    endfunction

    function automatic string tag(input int m);
        case (m)
            0: return "R3 mode0 level";
            1: return "R5 one-shot";
            2: return "R6 rate";
            3: return "R7 square";
            4: return "R8 sw strobe";
            default: return "R9 hw strobe";
        endcase
    endfunction

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) step();
        // R1: reset state
        chk("R1 reset out", int'(out), 0);
        rst_n = 1'b1;
        repeat (3) step();
        chk("R1 idle after reset", int'(out), 0);

        // table of mode runs
        for (int r = 0; r < NROW; r++) begin
            int m, n, t;
            m = int'(VEC[r][26:24]);
            n = int'(VEC[r][23:8]);
            t = int'(VEC[r][7:0]);
            set_mode(3'(m), (m == 1 || m == 5) ? 1'b0 : 1'b1);
            load(n);
            for (int k = 0; k <= t + 3 * n + 2; k++) begin
                chk(tag(m), int'(out), exp_out(m, n, t, k));
                if ((m == 1 || m == 5) && k + 1 == t) gate = 1'b1;
                step();
            end
        end

        // R4: gate low freezes mode 0, then R3 rewrite
        set_mode(3'd0, 1'b1);
        load(5);
        for (int k = 0; k <= 10; k++) begin
            if (k == 7) chk("R4 gate hold low", int'(out), 0);
            if (k == 8) chk("R4 gate hold rise", int'(out), 1);
            if (k == 2) gate = 1'b0;
            if (k == 5) gate = 1'b1;
            if (k < 10) step();
        end
        load(3);
        chk("R3 rewrite drops", int'(out), 0);
        step(); step();
        chk("R3 rewrite still low", int'(out), 0);
        step();
        chk("R3 rewrite rises", int'(out), 1);

        // R10: count rewrite restarts mode 4
        set_mode(3'd4, 1'b1);
        load(10);
        for (int k = 0; k <= 10; k++) begin
            if (k == 7) chk("R10 before strobe", int'(out), 1);
            if (k == 8) chk("R10 strobe", int'(out), 0);
            if (k == 9) chk("R10 after strobe", int'(out), 1);
            if (k == 10) chk("R10 old strobe gone", int'(out), 1);
            if (k == 3) begin
                wr_count = 1'b1; count_in = 16'd4;
            end else begin
                wr_count = 1'b0;
            end
            if (k < 10) step();
        end
        wr_count = 1'b0;

        // R9: retrigger reloads the count
        set_mode(3'd5, 1'b0);
        load(6);
        for (int k = 0; k <= 12; k++) begin
            if (k == 7) chk("R9 retrigger delays", int'(out), 1);
            if (k == 11) chk("R9 retrigger strobe", int'(out), 0);
            if (k == 12) chk("R9 retrigger recovers", int'(out), 1);
            if (k == 0) gate = 1'b1;
            if (k == 3) gate = 1'b0;
            if (k == 4) gate = 1'b1;
            if (k < 12) step();
        end

        // R5: trigger before arming is ignored
        set_mode(3'd1, 1'b0);
        gate = 1'b1;
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R5 unarmed ignored", int'(out), 1);
        end
        load(2);
        step();
        chk("R5 count write does not fire", int'(out), 1);
        gate = 1'b0;
        step();
        gate = 1'b1;
        step();
        chk("R5 armed fire", int'(out), 0);
        step();
        chk("R5 pulse length", int'(out), 0);
        step();
        chk("R5 pulse ends", int'(out), 1);

        // R2: code 7 acts as square wave
        set_mode(3'd7, 1'b1);
        load(4);
        step();
        chk("R2 alias high", int'(out), 1);
        step();
        chk("R2 alias low", int'(out), 0);
        step(); step();
        chk("R2 alias high again", int'(out), 1);

        // R11: odd count split
        set_mode(3'd3, 1'b1);
        load(7);
        for (int k = 0; k <= 7; k++) begin
            if (k == 3) chk("R11 high half end", int'(out), 1);
            if (k == 4) chk("R11 low half start", int'(out), 0);
            if (k == 6) chk("R11 low half end", int'(out), 0);
            if (k == 7) chk("R11 next high", int'(out), 1);
            if (k < 7) step();
        end

        finish_run();
    end
endmodule